// File: doc/BRIEF.md
# Multi-Channel APB Down-Counting Timer

This block is a bus-attached timer peripheral holding a parameterised set of independent down-counters (two by default, 32 bits wide). Each channel has a load register, a readable live count, a three-bit control register, a clear-on-read interrupt acknowledge location and a masked status location. A shared group of locations gives all channels' masked and raw interrupt flags as bit vectors, an acknowledge that clears every channel at once, and a fixed version word.

A channel counts down once per bus clock while enabled. On expiry it either reloads the programmed load value (periodic mode) or restarts from all ones (free-running mode), so software that inverts the live count sees a rising count. Each channel drives a level interrupt that follows its masked flag. The bus has no wait states: write data is taken at the end of the access phase, and read data is valid during it.

Top module: `apb_dtimer`

## Requirements
- R1: After reset every load, count and control register reads zero, no raw flag is set and every irq bit is low.
- R2: Channel n occupies byte offsets n*0x14 + {0x00 load, 0x04 live count, 0x08 control, 0x0C acknowledge, 0x10 masked status}. Load and control read back what was written. Control bit 0 enables counting, bit 1 selects periodic (1) or free-running (0), bit 2 masks the interrupt when 1.
- R3: Writing control with bit 0 set while the channel is disabled makes the count equal the load value at that edge; from then on the count drops by one each clock while enabled.
- R4: In periodic mode an enabled channel whose count is zero sets its raw flag and reloads the load value at the next edge, giving an expiry every load+1 clocks.
- R5: In free-running mode an enabled channel whose count is zero sets its raw flag and restarts from 0xFFFFFFFF.
- R6: While bit 0 of control is clear the count holds its value.
- R7: A read of a channel's acknowledge location returns zero and clears that channel's raw flag; other channels keep theirs.
- R8: A read at 0xA4 returns zero and clears the raw flags of all channels at the same edge.
- R9: A channel's masked flag is its raw flag with control bit 2 clear; irq[n] equals it. Offset 0xA0 returns all masked flags and 0xA8 all raw flags, channel n at bit n. Raising a flag wins over a clear in the same clock.
- R10: Offset 0xAC returns the VERSION parameter, unmapped offsets read zero, and writes to read-only locations change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW (8) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access phase |
| irq | output | NUM_CH (2) | Level interrupt per channel |

## Verification
The bench samples the live count at exact clocks after enabling, so an off-by-one in the start load or in the expiry period shows up as a wrong count or an interrupt one cycle early or late. Free-running wrap is checked by reading 0xFFFFFFFF right after expiry and a smaller value two clocks later, which catches a design that reloads the load value in both modes. A disabled channel is read twice to catch a counter that keeps running, and the acknowledge reads are checked per channel and combined, which catches a clear hitting the wrong channel or missing one. Masking is checked on both irq and the raw vector, so a mask that hides the raw flag is caught as well as one that fails to suppress the output.

// File: rtl/apb_dtimer.sv
module apb_dtimer #(
  parameter int          NUM_CH  = 2,
  parameter int          CW      = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] VERSION = 32'h0001_0203
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int STRIDE = 20;
  localparam logic [AW-1:0] A_STAT = AW'(8'hA0);
  localparam logic [AW-1:0] A_CEOI = AW'(8'hA4);
  localparam logic [AW-1:0] A_RAW  = AW'(8'hA8);
  localparam logic [AW-1:0] A_VER  = AW'(8'hAC);

  logic          acc, wr, rd, ceoi_rd;
  logic [CW-1:0] ld  [NUM_CH];
  logic [CW-1:0] cnt [NUM_CH];
  logic [2:0]    ctl [NUM_CH];
  logic [NUM_CH-1:0] raw, msk;

  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign rd      = acc & ~pwrite;
  assign ceoi_rd = rd && (paddr == A_CEOI);
  assign irq     = msk;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = i * STRIDE;
    logic          in_ch, ld_we, ctl_we, eoi_rd, en_rise, expire;
    logic [AW-1:0] off;

    assign in_ch   = (int'(paddr) >= BASE) && (int'(paddr) < BASE + STRIDE);
    assign off     = paddr - AW'(BASE);
    assign ld_we   = wr && in_ch && (off == AW'(0));
    assign ctl_we  = wr && in_ch && (off == AW'(8));
    assign eoi_rd  = rd && in_ch && (off == AW'(12));
    assign en_rise = ctl_we && pwdata[0] && !ctl[i][0];
    assign expire  = ctl[i][0] && (cnt[i] == '0);
    assign msk[i]  = raw[i] & ~ctl[i][2];

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        ld[i]  <= '0;
        cnt[i] <= '0;
        ctl[i] <= '0;
        raw[i] <= 1'b0;
      end else begin
        if (ld_we)  ld[i]  <= CW'(pwdata);
        if (ctl_we) ctl[i] <= pwdata[2:0];
        if (en_rise)        cnt[i] <= ld[i];
        else if (expire)    cnt[i] <= ctl[i][1] ? ld[i] : '1;
        else if (ctl[i][0]) cnt[i] <= cnt[i] - 1'b1;
        if (expire)                   raw[i] <= 1'b1;
        else if (eoi_rd || ceoi_rd)   raw[i] <= 1'b0;
      end
    end

    assert_decrement_R3: assert property (@(posedge pclk) disable iff (!presetn)
      ctl[i][0] && cnt[i] != '0 && !ctl_we |=> cnt[i] == $past(cnt[i]) - 1'b1);
    assert_periodic_reload_R4: assert property (@(posedge pclk) disable iff (!presetn)
      ctl[i][1:0] == 2'b11 && cnt[i] == '0 && !ctl_we |=> cnt[i] == $past(ld[i]) && raw[i]);
    assert_free_reload_R5: assert property (@(posedge pclk) disable iff (!presetn)
      ctl[i][1:0] == 2'b01 && cnt[i] == '0 && !ctl_we |=> cnt[i] == '1 && raw[i]);
    assert_freeze_R6: assert property (@(posedge pclk) disable iff (!presetn)
      !ctl[i][0] && !ctl_we |=> $stable(cnt[i]));
    assert_eoi_clear_R7: assert property (@(posedge pclk) disable iff (!presetn)
      eoi_rd && !(ctl[i][0] && cnt[i] == '0) |=> !raw[i]);
    assert_mask_R9: assert property (@(posedge pclk) disable iff (!presetn)
      ctl[i][2] |-> !irq[i]);
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (int'(paddr) >= k * STRIDE && int'(paddr) < k * STRIDE + STRIDE) begin
          case (int'(paddr) - k * STRIDE)
            0:       prdata = 32'(ld[k]);
            4:       prdata = 32'(cnt[k]);
            8:       prdata = {29'b0, ctl[k]};
            16:      prdata = {31'b0, msk[k]};
            default: prdata = '0;
          endcase
        end
      end
      case (paddr)
        A_STAT:  prdata = 32'(msk);
        A_RAW:   prdata = 32'(raw);
        A_VER:   prdata = VERSION;
        default: ;
      endcase
    end
  end
endmodule

// File: tb/sim_apb_dtimer.sv
module sim_apb_dtimer;
  localparam logic [31:0] VER = 32'h0001_0203;
  logic clk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic [1:0]  irq;
  int n_chk = 0, n_fail = 0;

  apb_dtimer #(.NUM_CH(2), .CW(32), .AW(8), .VERSION(VER)) u0 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk) penable = 1;
    #1 d = prdata;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {30'b0, irq}, 0);
    apb_rd(8'h00, v); chk("R1 load", v, 0);
    apb_rd(8'h04, v); chk("R1 count", v, 0);
    apb_rd(8'h1C, v); chk("R1 control", v, 0);
    apb_rd(8'hA8, v); chk("R1 raw", v, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    apb_wr(8'h14, 32'hDEADBEEF); apb_rd(8'h14, v); chk("R2 load ch1", v, 32'hDEADBEEF);
    apb_wr(8'h1C, 32'h6);        apb_rd(8'h1C, v); chk("R2 control ch1", v, 6);
    apb_wr(8'h18, 32'h1234);     apb_rd(8'h18, v); chk("R10 ro count", v, 0);
    apb_wr(8'hAC, 32'h0);        apb_rd(8'hAC, v); chk("R10 version", v, VER);
    apb_rd(8'h80, v); chk("R10 unmapped", v, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v, w;
    apb_wr(8'h00, 5); apb_wr(8'h08, 3);
    apb_rd(8'h04, v); chk("R3 count after 1 clk", v, 4);
    chk("R4 no early irq", {30'b0, irq}, 0);
    repeat (3) @(negedge clk);
    chk("R4 irq before period", {30'b0, irq}, 0);
    @(negedge clk);
    chk("R4 irq at period", {30'b0, irq}, 1);
    apb_rd(8'h04, v); chk("R4 reloaded count", v, 4);
    apb_wr(8'h08, 2);
    apb_rd(8'h04, v); repeat (3) @(negedge clk); apb_rd(8'h04, w);
    chk("R6 frozen", w, v);
    apb_rd(8'h0C, v); chk("R7 eoi data", v, 0);
    chk("R7 irq cleared", {30'b0, irq}, 0);
    apb_rd(8'h10, v); chk("R7 status cleared", v, 0);
  endtask

  task automatic t_free_mask;
    logic [31:0] v;
    apb_wr(8'h14, 3); apb_wr(8'h1C, 1);
    repeat (3) @(negedge clk);
    apb_rd(8'h18, v); chk("R5 wrap to ones", v, 32'hFFFFFFFF);
    apb_rd(8'h18, v); chk("R5 counting from ones", v, 32'hFFFFFFFD);
    chk("R5 irq", {30'b0, irq}, 2);
    apb_wr(8'h1C, 5);
    chk("R9 masked irq", {30'b0, irq}, 0);
    apb_rd(8'h24, v); chk("R9 masked status", v, 0);
    apb_rd(8'hA8, v); chk("R9 raw vector", v, 2);
    apb_rd(8'hA0, v); chk("R9 masked vector", v, 0);
    apb_wr(8'h1C, 1);
    apb_rd(8'hA0, v); chk("R9 unmasked vector", v, 2);
  endtask

  task automatic t_combined;
    logic [31:0] v;
    apb_wr(8'h00, 1); apb_wr(8'h08, 3);
    apb_wr(8'h08, 2); apb_wr(8'h1C, 0);
    apb_rd(8'hA8, v); chk("R8 both pending", v, 3);
    apb_rd(8'h0C + 8'h14, v);
    apb_rd(8'hA8, v); chk("R7 ch1 only cleared", v, 1);
    apb_wr(8'h1C, 1); repeat (2) @(negedge clk); apb_wr(8'h1C, 0);
    apb_rd(8'hA8, v); chk("R8 both pending again", v, 3);
    apb_rd(8'hA4, v); chk("R8 eoi data", v, 0);
    apb_rd(8'hA8, v); chk("R8 all cleared", v, 0);
    chk("R8 irq low", {30'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    presetn = 1;
    @(negedge clk);
    t_reset; t_regs; t_periodic; t_free_mask; t_combined;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule